// File: doc/BRIEF.md
# CCD Black-Level Reference Estimator

This block watches an interline CCD pixel stream and measures the black level from the light-shielded columns at a line edge. Each line starts with a run of empty positions that carry no charge. A run of shielded columns follows them. The first and last shielded columns pick up stray light, so they are left out. The remaining columns are averaged into a per-line dark value.

Lines that fall in the frame's image rows feed an exponential moving average. That average is the frame-smoothed reference. Shielded gray rows and buffer rows never move the reference. When the sensor is read through a single tap, a second group of shielded columns sits at the end of each line, and a select input can take the reference from that group instead.

Every incoming pixel is also passed out with the current reference subtracted, clamped at zero. It carries a flag that marks image rows, so downstream logic can drop gray and buffer rows.

Top module: `ccd_black_ref`

## Requirements
- R1: With `use_tail` low, only columns EMPTY_COLS+1 to EMPTY_COLS+SHIELD_COLS-2 are summed, counting columns from 0 at the pixel carrying `line_start`. The empty columns, both edge shielded columns and all other columns have no effect on `line_dark`.
- R2: With `use_tail` high, only columns LINE_LEN-SHIELD_COLS+1 to LINE_LEN-2 are summed. `use_tail` is held steady for a whole line.
- R3: `line_dark` is (S + floor(N/2)) / N rounded down, where S is the window sum and N = SHIELD_COLS-2. This rounds half up. It is computed with an exact reciprocal multiply and appears one cycle after the last window sample.
- R4: `line_dark_valid` pulses high for exactly one cycle per line, one cycle after the last window sample, and is low at all other times.
- R5: Rows are numbered from 0 at the line carrying `frame_start`. Rows LEAD_ROWS+BUF_ROWS to LEAD_ROWS+BUF_ROWS+IMAGE_ROWS-1 are image rows. `corr_image_row` is high with each output pixel of an image row and low otherwise. Lines that arrive after reset without a `frame_start` are not image rows.
- R6: `frame_dark` is A >> EMA_SHIFT for an accumulator A. The first image-row line after reset loads A = avg << EMA_SHIFT. Each later image-row line sets A = A - (A >> EMA_SHIFT) + avg. Both updates happen in the same cycle as `line_dark`. Lines outside the image rows leave `frame_dark` unchanged.
- R7: `corr_pix` = max(pixel - frame_dark, 0), one cycle after the pixel, using the `frame_dark` value present when the pixel arrives.
- R8: Cycles with `pix_valid` low advance no counter and add nothing to the sum. `corr_valid` follows `pix_valid` one cycle later.
- R9: Reset, active low and asynchronous, clears every output to zero and forgets the seeded reference.
- R10: A new `frame_start` restarts row numbering wherever the previous frame left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | PIX_W | Pixel value |
| line_start | input | 1 | Marks the first pixel of a line |
| frame_start | input | 1 | Marks the first pixel of a frame |
| use_tail | input | 1 | Take the reference from the trailing shielded columns |
| line_dark | output | PIX_W | Per-line dark average |
| line_dark_valid | output | 1 | One-cycle strobe for `line_dark` |
| frame_dark | output | PIX_W | Smoothed frame reference |
| corr_pix | output | PIX_W | Reference-subtracted pixel, clamped at zero |
| corr_valid | output | 1 | `corr_pix` is valid |
| corr_image_row | output | 1 | `corr_pix` belongs to an image row |

## Verification
Every result is due exactly one register stage after the input that causes it. The corrected pixel and its flags appear one cycle after the pixel. `line_dark`, its strobe and the updated `frame_dark` appear one cycle after the last window sample.

The bench drives each pixel on a falling edge. At the next falling edge it checks the outputs that pixel produced, before driving the next one. The expected reference is updated only after the correction for the last window pixel has been checked against the old value. Idle gaps inside a line check that `corr_valid` drops and that the per-line result is unchanged.

// File: rtl/ccd_black_ref.sv
module ccd_black_ref #(
  parameter int PIX_W       = 14,
  parameter int LINE_LEN    = 4960,
  parameter int EMPTY_COLS  = 12,
  parameter int SHIELD_COLS = 28,
  parameter int LEAD_ROWS   = 40,
  parameter int BUF_ROWS    = 16,
  parameter int IMAGE_ROWS  = 3248,
  parameter int EMA_SHIFT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             line_start,
  input  logic             frame_start,
  input  logic             use_tail,
  output logic [PIX_W-1:0] line_dark,
  output logic             line_dark_valid,
  output logic [PIX_W-1:0] frame_dark,
  output logic [PIX_W-1:0] corr_pix,
  output logic             corr_valid,
  output logic             corr_image_row
);
  localparam int USE_N  = SHIELD_COLS - 2;
  localparam int NLOG   = $clog2(USE_N);
  localparam int SUM_W  = PIX_W + NLOG + 1;
  localparam int X_W    = SUM_W + 1;
  localparam int FRAC   = X_W + NLOG;
  localparam int PROD_W = X_W + FRAC + 1;
  localparam logic [63:0] RECIP = ((64'd1 << FRAC) + 64'(USE_N - 1)) / 64'(USE_N);
  localparam int COL_W  = $clog2(LINE_LEN + 1);
  localparam int IMG_LO = LEAD_ROWS + BUF_ROWS;
  localparam int IMG_HI = IMG_LO + IMAGE_ROWS;
  localparam int ROW_W  = $clog2(IMG_HI + BUF_ROWS + 1) + 1;
  localparam int ACC_W  = PIX_W + EMA_SHIFT;
  localparam logic [COL_W-1:0] HEAD_LO = COL_W'(EMPTY_COLS + 1);
  localparam logic [COL_W-1:0] HEAD_HI = COL_W'(EMPTY_COLS + SHIELD_COLS - 2);
  localparam logic [COL_W-1:0] TAIL_LO = COL_W'(LINE_LEN - SHIELD_COLS + 1);
  localparam logic [COL_W-1:0] TAIL_HI = COL_W'(LINE_LEN - 2);

  logic [COL_W-1:0]  col_q, cur_col;
  logic [ROW_W-1:0]  row_q, cur_row;
  logic [SUM_W-1:0]  sum_q, sum_nx;
  logic [X_W-1:0]    xval;
  logic [PROD_W-1:0] prod;
  logic [PIX_W-1:0]  avg;
  logic [ACC_W-1:0]  acc_q, acc_nx;
  logic              seeded_q;

  wire [COL_W-1:0] win_lo  = use_tail ? TAIL_LO : HEAD_LO;
  wire [COL_W-1:0] win_hi  = use_tail ? TAIL_HI : HEAD_HI;
  wire             in_win  = pix_valid && cur_col >= win_lo && cur_col <= win_hi;
  wire             win_end = pix_valid && cur_col == win_hi;
  wire             img_row = cur_row >= ROW_W'(IMG_LO) && cur_row < ROW_W'(IMG_HI);

  always_comb begin
    if (line_start)                     cur_col = '0;
    else if (col_q == COL_W'(LINE_LEN)) cur_col = col_q;
    else                                cur_col = col_q + 1'b1;
    if (frame_start)                    cur_row = '0;
    else if (line_start && row_q != '1) cur_row = row_q + 1'b1;
    else                                cur_row = row_q;
  end

  assign sum_nx = (cur_col == win_lo ? '0 : sum_q) + SUM_W'(pix_data);
  assign xval   = X_W'(sum_nx) + X_W'(USE_N / 2);
  assign prod   = PROD_W'(xval) * PROD_W'(RECIP[FRAC:0]);
  assign avg    = PIX_W'(prod >> FRAC);
  assign acc_nx = seeded_q ? acc_q - (acc_q >> EMA_SHIFT) + ACC_W'(avg)
                           : ACC_W'(avg) << EMA_SHIFT;
  assign frame_dark = PIX_W'(acc_q >> EMA_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q           <= '0;
      row_q           <= '1;
      sum_q           <= '0;
      acc_q           <= '0;
      seeded_q        <= 1'b0;
      line_dark       <= '0;
      line_dark_valid <= 1'b0;
      corr_pix        <= '0;
      corr_valid      <= 1'b0;
      corr_image_row  <= 1'b0;
    end else begin
      line_dark_valid <= win_end;
      corr_valid      <= pix_valid;
      corr_image_row  <= pix_valid && img_row;
      if (pix_valid) begin
        col_q    <= cur_col;
        row_q    <= cur_row;
        corr_pix <= (pix_data > frame_dark) ? pix_data - frame_dark : '0;
      end
      if (in_win) sum_q <= sum_nx;
      if (win_end) line_dark <= avg;
      if (win_end && img_row) begin
        acc_q    <= acc_nx;
        seeded_q <= 1'b1;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> corr_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !corr_valid && !line_dark_valid); // R8
  AST_CORR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> corr_pix <= $past(pix_data)); // R7
  AST_DARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_dark_valid |=> !line_dark_valid); // R4
  AST_REF_ONLY_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_dark) |-> line_dark_valid && corr_image_row); // R6
endmodule

// File: tb/test_ccd_black_ref.sv
module test_ccd_black_ref;
  localparam int W = 8, LL = 20, EC = 2, SC = 7, LR = 2, BR = 1, IR = 3, SH = 2;
  localparam int N = SC - 2;
  localparam int HLO = EC + 1, HHI = EC + SC - 2, TLO = LL - SC + 1, THI = LL - 2;
  localparam int NV = 13;
  // {frame_start, use_tail, base, step, bump, active}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd10,  8'd1, 8'd0, 8'd50},
    {1'b0, 1'b0, 8'd20,  8'd0, 8'd0, 8'd60},
    {1'b0, 1'b0, 8'd30,  8'd2, 8'd3, 8'd40},
    {1'b0, 1'b0, 8'd12,  8'd1, 8'd0, 8'd100},
    {1'b0, 1'b1, 8'd20,  8'd0, 8'd2, 8'd5},
    {1'b0, 1'b0, 8'd40,  8'd3, 8'd3, 8'd200},
    {1'b0, 1'b0, 8'd255, 8'd0, 8'd0, 8'd255},
    {1'b0, 1'b1, 8'd9,   8'd0, 8'd0, 8'd1},
    {1'b1, 1'b0, 8'd50,  8'd0, 8'd0, 8'd80},
    {1'b0, 1'b0, 8'd1,   8'd0, 8'd0, 8'd7},
    {1'b0, 1'b0, 8'd2,   8'd0, 8'd0, 8'd7},
    {1'b0, 1'b0, 8'd0,   8'd0, 8'd0, 8'd3},
    {1'b0, 1'b1, 8'd60,  8'd0, 8'd0, 8'd255}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0, use_tail = 1'b0;
  logic [W-1:0] pix_data = '0;
  logic [W-1:0] line_dark, frame_dark, corr_pix;
  logic line_dark_valid, corr_valid, corr_image_row;

  always #2 clk = ~clk;

  ccd_black_ref #(.PIX_W(W), .LINE_LEN(LL), .EMPTY_COLS(EC), .SHIELD_COLS(SC),
    .LEAD_ROWS(LR), .BUF_ROWS(BR), .IMAGE_ROWS(IR), .EMA_SHIFT(SH)) i_ccd_black_ref (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .line_start(line_start), .frame_start(frame_start), .use_tail(use_tail),
    .line_dark(line_dark), .line_dark_valid(line_dark_valid), .frame_dark(frame_dark),
    .corr_pix(corr_pix), .corr_valid(corr_valid), .corr_image_row(corr_image_row));

  int checks = 0, fails = 0;
  int brow = 1000, exp_acc = 0, exp_ref = 0;
  bit seeded = 0;
  bit p_v = 0, p_img = 0, p_last = 0;
  int p_d = 0, p_sum = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic observe();
    if (p_v) begin
      chk(corr_valid == 1'b1, "R8 corr_valid", int'(corr_valid), 1);
      chk(int'(corr_pix) == (p_d > exp_ref ? p_d - exp_ref : 0), "R7 corr_pix",
          int'(corr_pix), (p_d > exp_ref ? p_d - exp_ref : 0));
      chk(corr_image_row == p_img, "R5 image flag", int'(corr_image_row), int'(p_img));
    end else
      chk(corr_valid == 1'b0, "R8 idle corr_valid", int'(corr_valid), 0);
    if (p_v && p_last) begin
      int av;
      av = (p_sum + N / 2) / N;
      chk(line_dark_valid == 1'b1, "R4 strobe", int'(line_dark_valid), 1);
      chk(int'(line_dark) == av, "R3 line_dark", int'(line_dark), av);
      if (p_img) begin
        if (!seeded) exp_acc = av << SH;
        else exp_acc = exp_acc - (exp_acc >> SH) + av;
        seeded = 1;
        exp_ref = exp_acc >> SH;
      end
      chk(int'(frame_dark) == exp_ref, "R6 frame_dark", int'(frame_dark), exp_ref);
    end else begin
      chk(line_dark_valid == 1'b0, "R4 no strobe", int'(line_dark_valid), 0);
      chk(int'(frame_dark) == exp_ref, "R6 held", int'(frame_dark), exp_ref);
    end
  endtask

  task automatic step(input bit v, input bit ls, input bit fs, input bit tl,
                      input int d, input bit img, input bit last, input int sum);
    @(negedge clk);
    observe();
    pix_valid = v; line_start = ls; frame_start = fs; use_tail = tl;
    pix_data = W'(d);
    p_v = v; p_d = d; p_img = img; p_last = last; p_sum = sum;
  endtask

  task automatic send_line(input bit fs, input bit tl, input int b, input int s,
                           input int bump, input int act, input int gap);
    int sum = 0;
    bit img;
    brow = fs ? 0 : brow + 1;
    img = (brow >= LR + BR) && (brow < LR + BR + IR);
    for (int c = 0; c < LL; c++) begin
      int px, k;
      int lo, hi;
      lo = tl ? TLO : HLO;
      hi = tl ? THI : HHI;
      if (c == gap) repeat (3) step(0, 0, 0, tl, 0, 0, 0, 0);
      if (c >= lo && c <= hi) begin
        k = c - lo;
        px = b + s * k + (k == 0 ? bump : 0);
        sum += px;
      end else if (c > HHI + 1 && c < TLO - 1) px = act;
      else px = 255;
      step(1, c == 0, fs && c == 0, tl, px, img, c == hi, sum);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(line_dark == 0 && frame_dark == 0 && corr_pix == 0, "R9 reset data",
        int'(line_dark) + int'(frame_dark) + int'(corr_pix), 0);
    chk(!line_dark_valid && !corr_valid && !corr_image_row, "R9 reset flags",
        int'(line_dark_valid) + int'(corr_valid) + int'(corr_image_row), 0);
    rst_n = 1'b1;
    // R1 R2 R3 R5 R6 R7 R10: table walk, two frames
    for (int i = 0; i < NV; i++)
      send_line(VEC[i][33], VEC[i][32], int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                int'(VEC[i][15:8]), int'(VEC[i][7:0]), -1);
    // R8: idle gaps inside the window and the active run
    send_line(0, 0, 30, 1, 0, 90, 5);
    send_line(0, 1, 7, 2, 1, 90, 16);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R9: reset in mid-run clears outputs and the seed
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(frame_dark == 0 && line_dark == 0 && corr_pix == 0, "R9 mid reset",
        int'(frame_dark) + int'(line_dark) + int'(corr_pix), 0);
    seeded = 0; exp_acc = 0; exp_ref = 0; brow = 1000; p_v = 0; p_last = 0;
    rst_n = 1'b1;
    // R5: line with no frame_start after reset is not an image row
    send_line(0, 0, 70, 0, 0, 20, -1);
    // R6: reseed from first image line of the new frame
    send_line(1, 0, 5, 0, 0, 20, -1);
    send_line(0, 0, 5, 0, 0, 20, -1);
    send_line(0, 0, 5, 0, 0, 20, -1);
    send_line(0, 0, 33, 0, 4, 20, -1);
    send_line(0, 1, 255, 0, 0, 0, -1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule